// File: doc/BRIEF.md
# Selectable Video Test Pattern Generator

This block drives a parallel 24-bit RGB video transmitter. Every pixel clock it produces a pixel word together with horizontal sync, vertical sync and data enable. Raster geometry (visible size, front porch, sync width and back porch for both axes) is set by parameters. The defaults describe 1920x1080 at 60 Hz with a 148.5 MHz pixel clock, so other resolutions need only new parameter values.

Seven test images are built in: eight-colour vertical bars, eight-colour horizontal stripes, a gray ramp that scrolls one pixel per frame, a black/white checkerboard, plain blue, a colour ramp, and a one-pixel white outline of the visible area. An active-low push-button input is synchronised and filtered. Each debounced press steps to the next image. A new choice is held back until the next frame begins, so a frame never mixes two images.

Top module: `patgen_top`

## Requirements
- R1: While reset is applied, dataEn and pixel are 0 and both syncs sit at their inactive level. The first frame after reset shows the vertical bars (image index 0).
- R2: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks and a frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. dataEn is high exactly for the first H_ACTIVE clocks of each of the first V_ACTIVE lines. Outputs lag the raster position by one clock.
- R3: hSync is active for H_SYNC clocks starting H_ACTIVE+H_FP clocks into every line. vSync is active for the whole of lines V_ACTIVE+V_FP up to V_ACTIVE+V_FP+V_SYNC-1. The active level is high when SYNC_ACTIVE_HIGH=1 and low when it is 0.
- R4: pixel is 0 whenever dataEn is low. pixel is packed as {red[23:16], green[15:8], blue[7:0]}.
- R5: Image 0 (vertical bars): region k = floor(x*8/H_ACTIVE) selects a colour, with k=0..7 giving white FFFFFF, yellow FFFF00, cyan 00FFFF, green 00FF00, magenta FF00FF, red FF0000, blue 0000FF, black 000000.
- R6: Image 1 (horizontal stripes): the same colours in the same order, with region floor(y*8/V_ACTIVE).
- R7: Image 2 (scrolling gray): every channel equals (x + s) mod 256. Here s is the count of frames since reset mod 256, which advances as each vertical sync begins.
- R8: Image 3 (checkerboard): white when bit CHECK_LOG2 of x equals bit CHECK_LOG2 of y, black otherwise.
- R9: Image 4 is solid blue 0000FF. Image 5 (colour ramp) has red = x mod 256, green = y mod 256 and blue = 255 - (x mod 256).
- R10: Image 6 (outline): white where x is 0 or H_ACTIVE-1, or y is 0 or V_ACTIVE-1. Black elsewhere.
- R11: Each falling edge of the debounced button level advances the selection by one, in index order 0..6, and wraps from 6 to 0. Two presses within one frame advance it by two.
- R12: The filtered button level changes only after the synchronised input has differed from it for DB_CYCLES consecutive clocks. A shorter low pulse changes nothing.
- R13: The shown image changes only at a frame boundary. The rest of the current frame keeps the old image. A press that registers on the last clock of a frame takes effect in the frame that starts next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| btnN | input | 1 | Raw push-button level, low while pressed |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| dataEn | output | 1 | High on visible pixels |
| pixel | output | 24 | RGB pixel word |

## Verification
Two events can fall in the same cycle: the debounced press that updates the pending selection, and the end-of-frame capture that copies the selection into the image in use. The bench times a button drop so that the filtered press registers exactly on the last clock of a frame. It then expects the very next frame to show the new image, checked pixel by pixel against a model of the raster. Mid-frame presses are judged the same way, and that check also catches a frame that changes image partway through.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

  typedef enum logic [2:0] {
    PAT_VBARS    = 3'd0,
    PAT_HSTRIPES = 3'd1,
    PAT_SCROLL   = 3'd2,
    PAT_CHECKER  = 3'd3,
    PAT_BLUE     = 3'd4,
    PAT_GRADIENT = 3'd5,
    PAT_BORDER   = 3'd6
  } patSel_e;

  // Raster strobes handed from control to datapath
  typedef struct packed {
    logic active;
    logic hSyncOn;
    logic vSyncOn;
  } rasterFlags_t;

  function automatic logic [23:0] barColor(input logic [2:0] idx);
    case (idx)
      3'd0:    return 24'hFFFFFF;
      3'd1:    return 24'hFFFF00;
      3'd2:    return 24'h00FFFF;
      3'd3:    return 24'h00FF00;
      3'd4:    return 24'hFF00FF;
      3'd5:    return 24'hFF0000;
      3'd6:    return 24'h0000FF;
      default: return 24'h000000;
    endcase
  endfunction

  function automatic patSel_e nextPattern(input patSel_e cur);
    logic [2:0] inc;
    inc = cur + 3'd1;
    return (cur == PAT_BORDER) ? PAT_VBARS : patSel_e'(inc);
  endfunction

endpackage

// File: rtl/patgen_debounce.sv
module patgen_debounce #(
  parameter int DB_CYCLES = 1485000
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnN,
  output logic press
);
  localparam int CNT_W = $clog2(DB_CYCLES + 1);

  logic             syncA, syncB;
  logic             stableLvl, stablePrev;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA      <= 1'b1;
      syncB      <= 1'b1;
      stableLvl  <= 1'b1;
      stablePrev <= 1'b1;
      holdCnt    <= '0;
    end else begin
      syncA      <= btnN;
      syncB      <= syncA;
      stablePrev <= stableLvl;
      if (syncB != stableLvl) begin
        if (holdCnt == CNT_W'(DB_CYCLES - 1)) begin
          stableLvl <= syncB;
          holdCnt   <= '0;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end else begin
        holdCnt <= '0;
      end
    end
  end

  // Press = falling edge of the filtered level
  assign press = stablePrev & ~stableLvl;

  // R12: filtered level only ever moves to the synchronised input level
  p_filter_follows_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stableLvl) |-> (stableLvl == $past(syncB)));

  // R11: a press is a single-cycle strobe
  p_press_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    press |=> !press);

endmodule

// File: rtl/patgen_ctrl.sv
module patgen_ctrl
  import patgen_pkg::*;
#(
  parameter int H_ACTIVE = 1920,
  parameter int H_FP     = 88,
  parameter int H_SYNC   = 44,
  parameter int H_BP     = 148,
  parameter int V_ACTIVE = 1080,
  parameter int V_FP     = 4,
  parameter int V_SYNC   = 5,
  parameter int V_BP     = 36,
  parameter int POS_W    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             press,
  output logic [POS_W-1:0] hPos,
  output logic [POS_W-1:0] vPos,
  output rasterFlags_t     flags,
  output patSel_e          pattern,
  output logic [7:0]       scroll
);
  localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HS_START = H_ACTIVE + H_FP;
  localparam int HS_END   = HS_START + H_SYNC;
  localparam int VS_START = V_ACTIVE + V_FP;
  localparam int VS_END   = VS_START + V_SYNC;

  logic [POS_W-1:0] hCount, vCount;
  logic             lastH, lastV, frameEnd;
  patSel_e          pendSel, pendNext, activeSel;

  assign lastH    = (hCount == POS_W'(H_TOTAL - 1));
  assign lastV    = (vCount == POS_W'(V_TOTAL - 1));
  assign frameEnd = lastH && lastV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (lastH) begin
      hCount <= '0;
      vCount <= lastV ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  always_comb begin
    flags.active  = (hCount < POS_W'(H_ACTIVE)) && (vCount < POS_W'(V_ACTIVE));
    flags.hSyncOn = (hCount >= POS_W'(HS_START)) && (hCount < POS_W'(HS_END));
    flags.vSyncOn = (vCount >= POS_W'(VS_START)) && (vCount < POS_W'(VS_END));
  end

  assign pendNext = press ? nextPattern(pendSel) : pendSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSel   <= PAT_VBARS;
      activeSel <= PAT_VBARS;
      scroll    <= '0;
    end else begin
      pendSel <= pendNext;
      if (frameEnd) activeSel <= pendNext;
      if (lastH && vCount == POS_W'(VS_START - 1)) scroll <= scroll + 8'd1;
    end
  end

  assign hPos    = hCount;
  assign vPos    = vCount;
  assign pattern = activeSel;

  // R2: raster counters stay inside the frame
  p_count_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hCount < POS_W'(H_TOTAL)) && (vCount < POS_W'(V_TOTAL)));

  // R13: the image in use changes only right after the last clock of a frame
  p_frame_only_r13: assert property (@(posedge clk) disable iff (!rstN)
    (activeSel != $past(activeSel)) |->
      ($past(hCount) == POS_W'(H_TOTAL - 1) && $past(vCount) == POS_W'(V_TOTAL - 1)));

  // R11: selection never leaves the seven valid images
  p_sel_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pendSel <= PAT_BORDER) && (activeSel <= PAT_BORDER));

  // R7: scroll offset moves only as vertical sync begins
  p_scroll_at_vsync_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(scroll) |-> (flags.vSyncOn && hCount == '0 && vCount == POS_W'(VS_START)));

endmodule

// File: rtl/patgen_datapath.sv
module patgen_datapath
  import patgen_pkg::*;
#(
  parameter int H_ACTIVE         = 1920,
  parameter int V_ACTIVE         = 1080,
  parameter int POS_W            = 12,
  parameter int CHECK_LOG2       = 6,
  parameter bit SYNC_ACTIVE_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] hPos,
  input  logic [POS_W-1:0] vPos,
  input  rasterFlags_t     flags,
  input  patSel_e          pattern,
  input  logic [7:0]       scroll,
  output logic             hSync,
  output logic             vSync,
  output logic             dataEn,
  output logic [23:0]      pixel
);
  localparam logic SYNC_ON = SYNC_ACTIVE_HIGH;

  logic [6:0]  hGe, vGe;
  logic [2:0]  hRegion, vRegion;
  logic [7:0]  gray;
  logic        onBorder, checkBit;
  logic [23:0] colorNext;

  // Region boundaries at ceil(i*ACTIVE/8)
  for (genvar i = 1; i < 8; i++) begin : g_bound
    localparam int HB = (i * H_ACTIVE + 7) / 8;
    localparam int VB = (i * V_ACTIVE + 7) / 8;
    assign hGe[i-1] = (hPos >= POS_W'(HB));
    assign vGe[i-1] = (vPos >= POS_W'(VB));
  end

  always_comb begin
    hRegion = '0;
    vRegion = '0;
    for (int k = 0; k < 7; k++) begin
      hRegion = hRegion + {2'b00, hGe[k]};
      vRegion = vRegion + {2'b00, vGe[k]};
    end
  end

  assign gray     = hPos[7:0] + scroll;
  assign checkBit = hPos[CHECK_LOG2] ^ vPos[CHECK_LOG2];
  assign onBorder = (hPos == '0) || (hPos == POS_W'(H_ACTIVE - 1)) ||
                    (vPos == '0) || (vPos == POS_W'(V_ACTIVE - 1));

  always_comb begin
    case (pattern)
      PAT_VBARS:    colorNext = barColor(hRegion);
      PAT_HSTRIPES: colorNext = barColor(vRegion);
      PAT_SCROLL:   colorNext = {gray, gray, gray};
      PAT_CHECKER:  colorNext = checkBit ? 24'h000000 : 24'hFFFFFF;
      PAT_BLUE:     colorNext = 24'h0000FF;
      PAT_GRADIENT: colorNext = {hPos[7:0], vPos[7:0], ~hPos[7:0]};
      PAT_BORDER:   colorNext = onBorder ? 24'hFFFFFF : 24'h000000;
      default:      colorNext = 24'h000000;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataEn <= 1'b0;
      pixel  <= '0;
      hSync  <= ~SYNC_ON;
      vSync  <= ~SYNC_ON;
    end else begin
      dataEn <= flags.active;
      pixel  <= flags.active ? colorNext : 24'h000000;
      hSync  <= flags.hSyncOn ? SYNC_ON : ~SYNC_ON;
      vSync  <= flags.vSyncOn ? SYNC_ON : ~SYNC_ON;
    end
  end

  // R4: blanked pixels are black
  p_blank_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dataEn |-> (pixel == 24'h0));

  // R3: horizontal and vertical sync never overlap visible data
  p_de_sync_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (hSync != SYNC_ON && vSync != SYNC_ON));

endmodule

// File: rtl/patgen_top.sv
module patgen_top
  import patgen_pkg::*;
#(
  parameter int H_ACTIVE         = 1920,
  parameter int H_FP             = 88,
  parameter int H_SYNC           = 44,
  parameter int H_BP             = 148,
  parameter int V_ACTIVE         = 1080,
  parameter int V_FP             = 4,
  parameter int V_SYNC           = 5,
  parameter int V_BP             = 36,
  parameter int POS_W            = 12,
  parameter int CHECK_LOG2       = 6,
  parameter bit SYNC_ACTIVE_HIGH = 1'b1,
  parameter int DB_CYCLES        = 1485000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        btnN,
  output logic        hSync,
  output logic        vSync,
  output logic        dataEn,
  output logic [23:0] pixel
);
  logic             press;
  logic [POS_W-1:0] hPos, vPos;
  rasterFlags_t     flags;
  patSel_e          pattern;
  logic [7:0]       scroll;

  patgen_debounce #(.DB_CYCLES(DB_CYCLES)) i_debounce (
    .clk(clk), .rstN(rstN), .btnN(btnN), .press(press)
  );

  patgen_ctrl #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .POS_W(POS_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .press(press), .hPos(hPos), .vPos(vPos),
    .flags(flags), .pattern(pattern), .scroll(scroll)
  );

  patgen_datapath #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .POS_W(POS_W),
    .CHECK_LOG2(CHECK_LOG2), .SYNC_ACTIVE_HIGH(SYNC_ACTIVE_HIGH)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .hPos(hPos), .vPos(vPos), .flags(flags),
    .pattern(pattern), .scroll(scroll), .hSync(hSync), .vSync(vSync),
    .dataEn(dataEn), .pixel(pixel)
  );

endmodule

// File: tb/test_patgen_top.sv
`timescale 1ns/1ps
module test_patgen_top;
  localparam int HA = 20, HFP = 2, HSW = 3, HBP = 3;
  localparam int VA = 12, VFP = 1, VSW = 2, VBP = 2;
  localparam int HT = HA + HFP + HSW + HBP;
  localparam int VT = VA + VFP + VSW + VBP;
  localparam int F  = HT * VT;
  localparam int DB = 6;
  localparam int CK = 2;
  localparam bit SYNC_LVL = 1'b0;

  logic clk = 1'b0, rstN = 1'b0, btnN = 1'b1;
  logic hSync, vSync, dataEn;
  logic [23:0] pixel;

  int checks = 0, errors = 0;
  int cyc = 0;
  int n, p, f, h, v;
  int selModel = 0, curPat = 0;
  string scen = "R1";
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  patgen_top #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSW), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSW), .V_BP(VBP),
    .POS_W(12), .CHECK_LOG2(CK), .SYNC_ACTIVE_HIGH(SYNC_LVL), .DB_CYCLES(DB)
  ) i_patgen_top (
    .clk(clk), .rstN(rstN), .btnN(btnN), .hSync(hSync), .vSync(vSync),
    .dataEn(dataEn), .pixel(pixel)
  );

  function automatic logic [23:0] barRef(input int k);
    case (k)
      0: return 24'hFFFFFF; 1: return 24'hFFFF00; 2: return 24'h00FFFF;
      3: return 24'h00FF00; 4: return 24'hFF00FF; 5: return 24'hFF0000;
      6: return 24'h0000FF; default: return 24'h000000;
    endcase
  endfunction

  function automatic logic [23:0] refPixel(input int x, input int y, input int pat, input int fr);
    int g;
    case (pat)
      0: return barRef(x * 8 / HA);
      1: return barRef(y * 8 / VA);
      2: begin g = (x + fr) % 256; return {g[7:0], g[7:0], g[7:0]}; end
      3: return ((((x >> CK) ^ (y >> CK)) & 1) == 0) ? 24'hFFFFFF : 24'h000000;
      4: return 24'h0000FF;
      5: begin g = 255 - (x % 256); return {8'(x % 256), 8'(y % 256), g[7:0]}; end
      default: return (x == 0 || x == HA-1 || y == 0 || y == VA-1) ? 24'hFFFFFF : 24'h000000;
    endcase
  endfunction

  function automatic string patTag(input int pat);
    case (pat)
      0: return "R5"; 1: return "R6"; 2: return "R7"; 3: return "R8";
      4, 5: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (scenario %s) n=%0d h=%0d v=%0d actual=%h expected=%h",
               tag, scen, n, h, v, act, exp);
    end
  endtask

  // One clock: compare every output against the raster model
  task automatic step();
    logic expDe, expHs, expVs;
    logic [23:0] expPix;
    @(negedge clk);
    n = cyc;
    p = (n - 1) % F;
    f = (n - 1) / F;
    h = p % HT;
    v = p / HT;
    if (p == 0) curPat = selModel;
    expDe  = (h < HA) && (v < VA);
    expHs  = (h >= HA + HFP && h < HA + HFP + HSW) ? SYNC_LVL : ~SYNC_LVL;
    expVs  = (v >= VA + VFP && v < VA + VFP + VSW) ? SYNC_LVL : ~SYNC_LVL;
    expPix = expDe ? refPixel(h, v, curPat, f) : 24'h0;
    check("R2", {31'b0, dataEn}, {31'b0, expDe});
    check("R3", {30'b0, hSync, vSync}, {30'b0, expHs, expVs});
    check(expDe ? patTag(curPat) : "R4", {8'b0, pixel}, {8'b0, expPix});
  endtask

  task automatic waitPos(input int target);
    do step(); while (p != target);
  endtask

  task automatic runFrame();
    waitPos(0);
    repeat (F - 1) step();
  endtask

  task automatic pressAt(input int pos);
    waitPos(pos);
    btnN = 1'b0;
    selModel = (selModel + 1) % 7;
    repeat (DB + 4) step();
    btnN = 1'b1;
    repeat (DB + 4) step();
  endtask

  task automatic tReset();
    scen = "R1";
    repeat (4) begin
      @(negedge clk);
      n = 0; h = 0; v = 0;
      check("R1", {7'b0, dataEn, pixel}, 32'h0);
      check("R1", {30'b0, hSync, vSync}, {30'b0, ~SYNC_LVL, ~SYNC_LVL});
    end
    rstN = 1'b1;
  endtask

  task automatic tFirstFrames();
    scen = "R1";
    repeat (F) step();
    scen = "R2";
    runFrame();
  endtask

  task automatic tCycleAll();
    scen = "R11";
    for (int k = 0; k < 7; k++) begin
      pressAt(5);
      runFrame();
      runFrame();
    end
    check("R11", selModel, 0);
  endtask

  task automatic tGlitch();
    scen = "R12";
    waitPos(5);
    btnN = 1'b0;
    repeat (DB - 3) step();
    btnN = 1'b1;
    runFrame();
    runFrame();
  endtask

  task automatic tDouble();
    scen = "R11";
    pressAt(3);
    pressAt(40);
    runFrame();
  endtask

  task automatic tBoundary();
    scen = "R13";
    pressAt(F - DB - 4);
    runFrame();
    pressAt(200);
    runFrame();
  endtask

  initial begin
    tReset();
    tFirstFrames();
    tCycleAll();
    tGlitch();
    tDouble();
    tBoundary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule